// File: doc/BRIEF.md
# Programmable Countdown Interval Timer

This block is an interval timer that counts down from a host-programmed byte value. It is paced by one of four tick sources, each derived inside the block from a 32.768 kHz clock enable through a chain of dividers. With the default ratios the sources run at 4096 Hz, 64 Hz, 1 Hz and once per minute. Each time the count runs out, the block raises a sticky timer flag, takes the programmed value again and keeps going, so it produces a steady stream of events at a fixed interval.

The host reaches the block through a simple byte-wide write port. Three addresses are decoded: a timer control byte (enable and source choice), a count byte (the reload value), and a shared control byte. In the shared byte the block owns the interrupt enable, the timer flag and the interrupt shape; the other bits of that byte belong to neighbouring logic and are ignored here. The active-low interrupt output either follows the flag as a level or drops for exactly one source period per event.

Top module: `countdown_timer`

## Requirements
- R1: After reset the count reads 0, the timer flag is 0, `irq_n` is 1, and the timer, its interrupt enable and pulse mode are all off.
- R2: Writes are decoded only at address 0x0E (timer control: bit 7 enable, bits 1:0 source), 0x0F (count value) and 0x01 (shared control: bit 0 interrupt enable, bit 2 timer flag, bit 4 pulse mode); a write to any other address changes nothing.
- R3: Source code 0 ticks every FAST_DIV reference enables, code 1 every FAST_DIV*MID_DIV, code 2 every FAST_DIV*MID_DIV*SEC_DIV, and code 3 every FAST_DIV*MID_DIV*SEC_DIV*MIN_DIV.
- R4: With the timer enabled and a nonzero count value N, the flag is set once every N source ticks; on the tick where the count is 1 it goes back to N and counting continues.
- R5: A count value of 0 keeps the timer idle: the count stays 0 and no flag is raised.
- R6: A write to the count address takes effect on the first enabled source tick after the write, where the count takes the newly written value.
- R7: While timer control bit 7 is 0, source ticks are ignored: the count holds its value and no flag is raised.
- R8: Writing the shared control byte with bit 2 at 0 clears the flag; with bit 2 at 1 the flag keeps its value.
- R9: In level mode (shared bit 4 = 0) with the interrupt enabled, `irq_n` is low exactly while the flag is set.
- R10: In pulse mode (shared bit 4 = 1) with the interrupt enabled, `irq_n` goes low with each timer event for exactly one source period, while the flag is still set and held.
- R11: With the interrupt enable (shared bit 0) at 0, `irq_n` stays high whatever the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | 32.768 kHz reference clock enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| cnt_value | output | DATA_W | Current count |
| tmr_flag | output | 1 | Sticky timer event flag |
| irq_n | output | 1 | Timer interrupt, active low |

## Verification
The bench builds the timer with divider ratios 2, 3, 2 and 3 and holds `ref_en` high, so the four sources tick every 2, 6, 12 and 36 clock cycles. With these short periods the once-per-minute source, multi-tick intervals on every source and the one-period pulse width can all be measured in a few hundred cycles. With the default ratios, a single minute would take close to two million reference enables.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // register addresses decoded by the timer
   localparam int unsigned SHARED_ADDR = 1;
   localparam int unsigned TCTL_ADDR   = 14;
   localparam int unsigned TCNT_ADDR   = 15;

   // field positions
   localparam int unsigned TIE_BIT  = 0;
   localparam int unsigned FLAG_BIT = 2;
   localparam int unsigned MODE_BIT = 4;
   localparam int unsigned EN_BIT   = 7;

   localparam int unsigned NUM_SRC  = 4;
   localparam int unsigned RATIO_W  = 16;

   typedef enum logic [1:0] {
      SRC_FAST = 2'd0,
      SRC_MID  = 2'd1,
      SRC_SEC  = 2'd2,
      SRC_MIN  = 2'd3
   } src_e;

endpackage

// File: rtl/tmr_div_stage.sv
module tmr_div_stage #(
   parameter int unsigned RATIO = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_out
);
   localparam int unsigned W = (RATIO <= 2) ? 1 : $clog2(RATIO);

   logic [W-1:0] cnt_q;
   logic         wrap;

   assign wrap = (cnt_q == W'(RATIO - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         tick_out <= 1'b0;
      end else begin
         tick_out <= tick_in && wrap;
         if (tick_in) begin
            if (wrap) cnt_q <= '0;
            else      cnt_q <= cnt_q + W'(1);
         end
      end
   end
endmodule

// File: rtl/tmr_rate_chain.sv
module tmr_rate_chain
   import tmr_pkg::*;
#(
   parameter int unsigned FAST_DIV = 8,
   parameter int unsigned MID_DIV  = 64,
   parameter int unsigned SEC_DIV  = 64,
   parameter int unsigned MIN_DIV  = 60
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_en,
   output logic [NUM_SRC-1:0] ticks
);
   localparam logic [NUM_SRC*RATIO_W-1:0] RATIO_VEC = {
      RATIO_W'(MIN_DIV), RATIO_W'(SEC_DIV), RATIO_W'(MID_DIV), RATIO_W'(FAST_DIV)
   };

   logic [NUM_SRC-1:0] chain_in;
   assign chain_in = {ticks[NUM_SRC-2:0], ref_en};

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_stage
      localparam int unsigned STAGE_RATIO = int'(RATIO_VEC[g*RATIO_W +: RATIO_W]);
      if (STAGE_RATIO < 2) begin : g_bad
         $error("divider stage ratio must be at least 2");
      end
      tmr_div_stage #(.RATIO(STAGE_RATIO)) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_in  (chain_in[g]),
         .tick_out (ticks[g])
      );
   end
endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         en,
   input  logic [W-1:0] reload,
   input  logic         load_req,
   output logic [W-1:0] cnt,
   output logic         fire
);
   logic pend_q;
   logic step;

   assign step = tick && en;
   assign fire = step && !pend_q && (cnt == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         pend_q <= 1'b0;
      end else begin
         if (step) begin
            if (pend_q || cnt == '0 || fire) cnt <= reload;
            else                             cnt <= cnt - W'(1);
         end
         if (load_req)  pend_q <= 1'b1;
         else if (step) pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr_irq_shaper.sv
module tmr_irq_shaper (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fire,
   input  logic clr,
   input  logic tie,
   input  logic pulse_mode,
   output logic flag,
   output logic irq_n
);
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (fire)     flag <= 1'b1;
         else if (clr) flag <= 1'b0;
         if (tick)     pulse_q <= fire && pulse_mode;
      end
   end

   assign irq_n = !(tie && (pulse_mode ? pulse_q : flag));
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned FAST_DIV = 8,
   parameter int unsigned MID_DIV  = 64,
   parameter int unsigned SEC_DIV  = 64,
   parameter int unsigned MIN_DIV  = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] cnt_value,
   output logic              tmr_flag,
   output logic              irq_n
);
   if (DATA_W < EN_BIT + 1) begin : g_bad_data
      $error("DATA_W must hold the enable bit");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must reach the count address");
   end
   if (FAST_DIV >= 2**RATIO_W || MID_DIV >= 2**RATIO_W ||
       SEC_DIV >= 2**RATIO_W || MIN_DIV >= 2**RATIO_W) begin : g_bad_ratio
      $error("divider ratio too wide");
   end

   logic [NUM_SRC-1:0] ticks;
   logic               sel_tick;
   logic               fire;
   logic               wr_shared, wr_tctl, wr_tcnt;

   logic               tmr_en_q;
   src_e               src_q;
   logic [DATA_W-1:0]  reload_q;
   logic               tie_q;
   logic               mode_q;

   assign wr_shared = wr_en && (wr_addr == ADDR_W'(SHARED_ADDR));
   assign wr_tctl   = wr_en && (wr_addr == ADDR_W'(TCTL_ADDR));
   assign wr_tcnt   = wr_en && (wr_addr == ADDR_W'(TCNT_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_en_q <= 1'b0;
         src_q    <= SRC_FAST;
         reload_q <= '0;
         tie_q    <= 1'b0;
         mode_q   <= 1'b0;
      end else begin
         if (wr_tctl) begin
            tmr_en_q <= wr_data[EN_BIT];
            src_q    <= src_e'(wr_data[1:0]);
         end
         if (wr_tcnt) reload_q <= wr_data;
         if (wr_shared) begin
            tie_q  <= wr_data[TIE_BIT];
            mode_q <= wr_data[MODE_BIT];
         end
      end
   end

   tmr_rate_chain #(
      .FAST_DIV (FAST_DIV),
      .MID_DIV  (MID_DIV),
      .SEC_DIV  (SEC_DIV),
      .MIN_DIV  (MIN_DIV)
   ) u_rates (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_en (ref_en),
      .ticks  (ticks)
   );

   assign sel_tick = ticks[src_q];

   tmr_down_core #(.W(DATA_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sel_tick),
      .en       (tmr_en_q),
      .reload   (reload_q),
      .load_req (wr_tcnt),
      .cnt      (cnt_value),
      .fire     (fire)
   );

   tmr_irq_shaper u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (sel_tick),
      .fire       (fire),
      .clr        (wr_shared && !wr_data[FLAG_BIT]),
      .tie        (tie_q),
      .pulse_mode (mode_q),
      .flag       (tmr_flag),
      .irq_n      (irq_n)
   );
endmodule

// File: rtl/countdown_timer_chk.sv
module countdown_timer_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] cnt_value,
   input logic              tmr_flag,
   input logic              irq_n,
   input logic              tmr_en,
   input logic              tie,
   input logic              mode,
   input logic [DATA_W-1:0] reload
);
   // R4: a flag rise comes only from the tick where the count was 1
   a_r4_flag_rise_at_one: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_flag) |-> $past(cnt_value) == DATA_W'(1));

   // R4: the count only steps down by one or takes the reload value
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_value != $past(cnt_value)) |->
         (cnt_value == $past(cnt_value) - DATA_W'(1) || cnt_value == $past(reload)));

   // R5: idle at zero raises no flag
   a_r5_idle_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (reload == '0 && cnt_value == '0) |=> !$rose(tmr_flag));

   // R7: disabled timer holds its count
   a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en && $past(!tmr_en)) |-> $stable(cnt_value));

   // R9: level mode tracks the flag
   a_r9_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (tie && !mode) |-> (irq_n == !tmr_flag));

   // R11: interrupt masked
   a_r11_tie_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !tie |-> irq_n);
endmodule

bind countdown_timer countdown_timer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_value (cnt_value),
   .tmr_flag  (tmr_flag),
   .irq_n     (irq_n),
   .tmr_en    (tmr_en_q),
   .tie       (tie_q),
   .mode      (mode_q),
   .reload    (reload_q)
);

// File: tb/countdown_timer_bench.sv
`timescale 1ns/1ps
module countdown_timer_bench;
   localparam int D0 = 2, D1 = 3, D2 = 2, D3 = 3;
   localparam int P0 = D0, P1 = P0 * D1, P2 = P1 * D2, P3 = P2 * D3;
   localparam int NV = 6;
   localparam int VSEL [NV] = '{0, 1, 2, 3, 1, 0};
   localparam int VRL  [NV] = '{5, 3, 2, 2, 1, 40};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] cnt_value;
   logic       tmr_flag;
   logic       irq_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   countdown_timer #(
      .ADDR_W(4), .DATA_W(8),
      .FAST_DIV(D0), .MID_DIV(D1), .SEC_DIV(D2), .MIN_DIV(D3)
   ) u_countdown_timer (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_value(cnt_value), .tmr_flag(tmr_flag), .irq_n(irq_n)
   );

   function automatic int src_period(input int sel);
      case (sel)
         0: return P0;
         1: return P1;
         2: return P2;
         default: return P3;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_flag(input int limit, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < limit; i++) begin
         if (tmr_flag) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      bit seen;
      longint t0, t1;
      int base, n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(cnt_value == 8'd0, "R1 count", cnt_value, 0);
      chk(tmr_flag == 1'b0, "R1 flag", tmr_flag, 0);
      chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);

      // R2 other addresses ignored: 0x05 written like a timer enable
      wr(4'hF, 8'd4);
      wr(4'h5, 8'h80);
      repeat (40) @(negedge clk);
      chk(cnt_value == 8'd0, "R2 stray address", cnt_value, 0);

      // R3 / R4 interval per source and count value
      for (int i = 0; i < NV; i++) begin
         int per;
         per = VRL[i] * src_period(VSEL[i]);
         wr(4'hE, 8'h00);
         wr(4'hF, 8'(VRL[i]));
         wr(4'hE, 8'h80 | 8'(VSEL[i]));
         wr(4'h1, 8'h00);
         wait_flag(3 * per + 100, seen);
         t0 = $time;
         wr(4'h1, 8'h00);
         wait_flag(3 * per + 100, seen);
         t1 = $time;
         chk(seen && ((t1 - t0) / 8) == per, "R3 R4 interval",
             int'((t1 - t0) / 8), per);
      end

      // R7 disabled timer holds
      wr(4'hE, 8'h00);
      wr(4'h1, 8'h00);
      base = cnt_value;
      repeat (60) @(negedge clk);
      chk(cnt_value == base, "R7 count held", cnt_value, base);
      chk(tmr_flag == 1'b0, "R7 no flag", tmr_flag, 0);

      // R6 count write restarts from new value
      wr(4'hF, 8'd9);
      wr(4'hE, 8'h81);
      repeat (30) @(negedge clk);
      wr(4'hF, 8'd200);
      base = cnt_value;
      for (int i = 0; i < 20; i++) begin
         if (cnt_value != base) break;
         @(negedge clk);
      end
      chk(cnt_value == 8'd200, "R6 restart value", cnt_value, 200);

      // R5 zero count stays idle
      wr(4'hE, 8'h00);
      wr(4'hF, 8'd0);
      wr(4'hE, 8'h80);
      wr(4'h1, 8'h00);
      repeat (100) @(negedge clk);
      chk(tmr_flag == 1'b0, "R5 no flag", tmr_flag, 0);
      chk(cnt_value == 8'd0, "R5 count zero", cnt_value, 0);

      // R9 level mode
      wr(4'hE, 8'h00);
      wr(4'hF, 8'd2);
      wr(4'h1, 8'h01);
      wr(4'hE, 8'h80);
      wait_flag(200, seen);
      chk(seen && irq_n == 1'b0, "R9 level low", irq_n, 0);
      wr(4'hE, 8'h00);

      // R11 masked interrupt, flag kept by writing bit 2 as 1
      wr(4'h1, 8'h04);
      chk(irq_n == 1'b1, "R11 masked irq_n", irq_n, 1);
      chk(tmr_flag == 1'b1, "R8 flag kept", tmr_flag, 1);

      // R8 clear semantics
      wr(4'h1, 8'h05);
      chk(tmr_flag == 1'b1, "R8 flag kept again", tmr_flag, 1);
      chk(irq_n == 1'b0, "R9 level low again", irq_n, 0);
      wr(4'h1, 8'h01);
      chk(tmr_flag == 1'b0, "R8 flag cleared", tmr_flag, 0);
      chk(irq_n == 1'b1, "R9 level released", irq_n, 1);

      // R10 pulse mode lasts one source period
      wr(4'hF, 8'd3);
      wr(4'h1, 8'h11);
      wr(4'hE, 8'h81);
      for (int i = 0; i < 200; i++) begin
         if (!irq_n) break;
         @(negedge clk);
      end
      n = 0;
      for (int i = 0; i < 100; i++) begin
         if (irq_n) break;
         n++;
         @(negedge clk);
      end
      chk(n == P1, "R10 pulse width", n, P1);
      chk(tmr_flag == 1'b1, "R10 flag held", tmr_flag, 1);

      finish_run();
   end
endmodule